// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a NOR-style flash. Every bus write (a single-cycle strobe that stands for the trailing edge of the write-enable or chip-enable pin) brings a command byte in data bits 7:0, plus an address and a data word. From these writes the decoder keeps track of what a read returns: array data, the status register, the signature or the query table. It also assembles the one-, two- and three-write instructions. Program, erase and protection work is handed to a sequencer and a protection unit as a single-cycle start request. That request carries an operation code with the latched addresses and data.

The decoder watches three status inputs: `busy`, `ers_susp` and `prg_susp`. From them it picks the set of commands that is legal at that moment. Busy has priority, then erase-suspended, then program-suspended. A wrong confirm byte, or a double-word pair whose addresses do not match, raises `seq_err`. That pulse asks the status register to set its two error bits (bits 4 and 5). A status snapshot is taken when a read access begins and is held for the rest of that access.

All requests and mode changes are registered. They appear in the clock cycle after the strobed edge, and the request pulses last exactly one cycle.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read selection `rd_sel` is 0 (array) and no request output is high.
- R2: A single write of FFh, 70h, 90h or 98h sets `rd_sel` to 0 (array), 1 (status), 2 (signature) or 3 (query) respectively.
- R3: A write of 50h pulses `clr_req` for one cycle and leaves `rd_sel` at 0, so the next read returns the array.
- R4: 20h followed by D0h pulses `op_start` with `op_kind` 0 (erase) and the address of the D0h write. 40h or 10h followed by any write pulses `op_start` with `op_kind` 1 (program) and that write's address and data. After any start `rd_sel` is 1.
- R5: 30h followed by two writes whose addresses differ only in bit 0 pulses `op_start` with `op_kind` 2. The first write goes out on `op_addr`/`op_data` and the second on `op_addr2`/`op_data2`. If the two addresses differ in any other bit, `seq_err` pulses instead and nothing starts.
- R6: 60h followed by 01h, D0h or 2Fh starts `op_kind` 3 (protect), 4 (unprotect) or 5 (lock) at that write's address. C0h followed by any write starts `op_kind` 6 (protection-register program) with that address and data.
- R7: After 20h or 60h, a second write that is not one of its confirm bytes pulses `seq_err`, starts nothing and returns the decoder to idle.
- R8: While `busy` is high, `rd_sel` reads 1. Only 70h (status read) and B0h are accepted, and B0h pulses `susp_req`. Every other write changes nothing, so the read mode held from before the busy period returns once `busy` falls.
- R9: With erase suspended, the legal commands are D0h, 40h/10h, FFh, 70h, 90h, 98h, 60h and C0h. With program suspended, only D0h, FFh, 70h, 90h and 98h are legal. D0h pulses `resume_req` and sets `rd_sel` to 1.
- R10: When not busy, an illegal command byte sets `rd_sel` to 0 and raises no request. This includes B0h or D0h while no operation is suspended.
- R11: `stat_out` takes the value of `stat_in` at the first cycle in which `rd_act` is high, and holds it until `rd_act` has fallen and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; bits 7:0 carry the command byte |
| busy | input | 1 | Program/erase sequencer is running |
| ers_susp | input | 1 | Erase is suspended |
| prg_susp | input | 1 | Program is suspended |
| rd_act | input | 1 | Read access in progress |
| stat_in | input | SW | Live status register value |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 signature, 3 query |
| stat_out | output | SW | Status snapshot for the current read access |
| op_start | output | 1 | One-cycle operation start request |
| op_kind | output | 3 | Operation code (see R4 to R6) |
| op_addr | output | AW | First or only operation address |
| op_data | output | DW | First or only operation data |
| op_addr2 | output | AW | Second double-word address |
| op_data2 | output | DW | Second double-word data |
| susp_req | output | 1 | Suspend request pulse |
| resume_req | output | 1 | Resume request pulse |
| clr_req | output | 1 | Clear-status request pulse |
| seq_err | output | 1 | Request to set status error bits 4 and 5 |

## Verification
The assertions check rules that hold on every cycle:
- Every request follows a strobed write.
- No start is issued while busy or while program is suspended.
- Suspend is requested only during a busy period, and resume only while suspended.
- A double-word start always carries a matching address pair.
- The status snapshot stays stable inside a read access.

Only the bench scenarios can show the rest:
- The read mode chosen by each command byte.
- The decoding of the confirm bytes.
- That ignored writes during a busy period leave the earlier mode in place.
- The exact addresses and data handed out.
- How the two suspended legal sets differ.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam logic [7:0] C_RD_ARRAY = 8'hFF;
    localparam logic [7:0] C_RD_STAT  = 8'h70;
    localparam logic [7:0] C_RD_SIG   = 8'h90;
    localparam logic [7:0] C_RD_QRY   = 8'h98;
    localparam logic [7:0] C_CLR      = 8'h50;
    localparam logic [7:0] C_SUSP     = 8'hB0;
    localparam logic [7:0] C_CONFIRM  = 8'hD0;
    localparam logic [7:0] C_ERASE    = 8'h20;
    localparam logic [7:0] C_PROG     = 8'h40;
    localparam logic [7:0] C_PROG_ALT = 8'h10;
    localparam logic [7:0] C_DWPROG   = 8'h30;
    localparam logic [7:0] C_PSETUP   = 8'h60;
    localparam logic [7:0] C_PROT     = 8'h01;
    localparam logic [7:0] C_LOCK     = 8'h2F;
    localparam logic [7:0] C_PREG     = 8'hC0;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_SIG    = 2'd2,
        RM_QUERY  = 2'd3
    } rmode_t;

    typedef enum logic [2:0] {
        OP_ERASE  = 3'd0,
        OP_PROG   = 3'd1,
        OP_DWPROG = 3'd2,
        OP_PROT   = 3'd3,
        OP_UNPROT = 3'd4,
        OP_LOCK   = 3'd5,
        OP_PREG   = 3'd6
    } op_t;

    typedef enum logic [1:0] {
        CX_IDLE  = 2'd0,
        CX_BUSY  = 2'd1,
        CX_ESUSP = 2'd2,
        CX_PSUSP = 2'd3
    } ctx_t;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_ERASE = 3'd1,
        SQ_PROG  = 3'd2,
        SQ_DW1   = 3'd3,
        SQ_DW2   = 3'd4,
        SQ_PROT  = 3'd5,
        SQ_PREG  = 3'd6
    } seq_t;

    typedef struct packed {
        logic start;
        logic susp;
        logic resume;
        logic clr;
        logic err;
    } req_t;

    function automatic logic is_read_cmd(input logic [7:0] c);
        return (c == C_RD_ARRAY) || (c == C_RD_STAT) || (c == C_RD_SIG) || (c == C_RD_QRY);
    endfunction

    function automatic logic cmd_legal(input ctx_t cx, input logic [7:0] c);
        logic ok;
        case (cx)
            CX_IDLE:  ok = is_read_cmd(c) || c == C_CLR || c == C_ERASE || c == C_PROG ||
                           c == C_PROG_ALT || c == C_DWPROG || c == C_PSETUP || c == C_PREG;
            CX_BUSY:  ok = (c == C_RD_STAT) || (c == C_SUSP);
            CX_ESUSP: ok = is_read_cmd(c) || c == C_CONFIRM || c == C_PROG ||
                           c == C_PROG_ALT || c == C_PSETUP || c == C_PREG;
            default:  ok = is_read_cmd(c) || c == C_CONFIRM;
        endcase
        return ok;
    endfunction

    function automatic rmode_t read_mode_of(input logic [7:0] c);
        rmode_t m;
        case (c)
            C_RD_STAT: m = RM_STATUS;
            C_RD_SIG:  m = RM_SIG;
            C_RD_QRY:  m = RM_QUERY;
            default:   m = RM_ARRAY;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fcd_ctx.sv
module fcd_ctx
    import fcd_pkg::*;
(
    input  logic busy,
    input  logic ers_susp,
    input  logic prg_susp,
    output ctx_t ctx
);
    always_comb begin
        if (busy)          ctx = CX_BUSY;
        else if (ers_susp) ctx = CX_ESUSP;
        else if (prg_susp) ctx = CX_PSUSP;
        else               ctx = CX_IDLE;
    end
endmodule

// File: rtl/fcd_stat_cap.sv
module fcd_stat_cap #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_act,
    input  logic [SW-1:0] stat_in,
    output logic [SW-1:0] stat_out
);
    logic rd_act_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_act_d <= 1'b0;
            stat_out <= '0;
        end else begin
            rd_act_d <= rd_act;
            if (rd_act && !rd_act_d) stat_out <= stat_in;
        end
    end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  ctx_t          ctx,
    output rmode_t        mode,
    output req_t          req,
    output op_t           op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic [AW-1:0] op_addr2,
    output logic [DW-1:0] op_data2
);
    localparam int CW = 8;

    seq_t          st, st_n;
    rmode_t        mode_n;
    req_t          req_n;
    op_t           kind_n;
    logic [AW-1:0] a1_q, a1_n, oa_n, oa2_n;
    logic [DW-1:0] d1_q, d1_n, od_n, od2_n;
    logic [CW-1:0] code;

    assign code = wr_data[CW-1:0];

    always_comb begin
        st_n   = st;
        mode_n = mode;
        req_n  = '0;
        kind_n = op_kind;
        a1_n   = a1_q;
        d1_n   = d1_q;
        oa_n   = op_addr;
        od_n   = op_data;
        oa2_n  = op_addr2;
        od2_n  = op_data2;
        if (wr_stb) begin
            case (st)
                SQ_IDLE: begin
                    if (ctx == CX_BUSY) begin
                        if (code == C_RD_STAT)  mode_n = RM_STATUS;
                        else if (code == C_SUSP) req_n.susp = 1'b1;
                    end else if (!cmd_legal(ctx, code)) begin
                        mode_n = RM_ARRAY;
                    end else begin
                        case (code)
                            C_CLR: begin
                                req_n.clr = 1'b1;
                                mode_n    = RM_ARRAY;
                            end
                            C_CONFIRM: begin
                                req_n.resume = 1'b1;
                                mode_n       = RM_STATUS;
                            end
                            C_ERASE:             st_n = SQ_ERASE;
                            C_PROG, C_PROG_ALT:  st_n = SQ_PROG;
                            C_DWPROG:            st_n = SQ_DW1;
                            C_PSETUP:            st_n = SQ_PROT;
                            C_PREG:              st_n = SQ_PREG;
                            default:             mode_n = read_mode_of(code);
                        endcase
                    end
                end
                SQ_ERASE: begin
                    st_n   = SQ_IDLE;
                    mode_n = RM_STATUS;
                    if (code == C_CONFIRM) begin
                        req_n.start = 1'b1;
                        kind_n      = OP_ERASE;
                        oa_n        = wr_addr;
                    end else begin
                        req_n.err = 1'b1;
                    end
                end
                SQ_PROG, SQ_PREG: begin
                    req_n.start = 1'b1;
                    kind_n      = (st == SQ_PROG) ? OP_PROG : OP_PREG;
                    oa_n        = wr_addr;
                    od_n        = wr_data;
                    st_n        = SQ_IDLE;
                    mode_n      = RM_STATUS;
                end
                SQ_DW1: begin
                    a1_n = wr_addr;
                    d1_n = wr_data;
                    st_n = SQ_DW2;
                end
                SQ_DW2: begin
                    st_n   = SQ_IDLE;
                    mode_n = RM_STATUS;
                    if (wr_addr[AW-1:1] == a1_q[AW-1:1]) begin
                        req_n.start = 1'b1;
                        kind_n      = OP_DWPROG;
                        oa_n        = a1_q;
                        od_n        = d1_q;
                        oa2_n       = wr_addr;
                        od2_n       = wr_data;
                    end else begin
                        req_n.err = 1'b1;
                    end
                end
                SQ_PROT: begin
                    st_n   = SQ_IDLE;
                    mode_n = RM_STATUS;
                    oa_n   = wr_addr;
                    case (code)
                        C_PROT:    begin req_n.start = 1'b1; kind_n = OP_PROT;   end
                        C_CONFIRM: begin req_n.start = 1'b1; kind_n = OP_UNPROT; end
                        C_LOCK:    begin req_n.start = 1'b1; kind_n = OP_LOCK;   end
                        default:   req_n.err = 1'b1;
                    endcase
                end
                default: st_n = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            mode     <= RM_ARRAY;
            req      <= '0;
            op_kind  <= OP_ERASE;
            a1_q     <= '0;
            d1_q     <= '0;
            op_addr  <= '0;
            op_data  <= '0;
            op_addr2 <= '0;
            op_data2 <= '0;
        end else begin
            st       <= st_n;
            mode     <= mode_n;
            req      <= req_n;
            op_kind  <= kind_n;
            a1_q     <= a1_n;
            d1_q     <= d1_n;
            op_addr  <= oa_n;
            op_data  <= od_n;
            op_addr2 <= oa2_n;
            op_data2 <= od2_n;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 16,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          busy,
    input  logic          ers_susp,
    input  logic          prg_susp,
    input  logic          rd_act,
    input  logic [SW-1:0] stat_in,
    output logic [1:0]    rd_sel,
    output logic [SW-1:0] stat_out,
    output logic          op_start,
    output logic [2:0]    op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic [AW-1:0] op_addr2,
    output logic [DW-1:0] op_data2,
    output logic          susp_req,
    output logic          resume_req,
    output logic          clr_req,
    output logic          seq_err
);
    ctx_t   ctx;
    rmode_t mode;
    req_t   req;
    op_t    kind;

    fcd_ctx u_ctx (
        .busy     (busy),
        .ers_susp (ers_susp),
        .prg_susp (prg_susp),
        .ctx      (ctx)
    );

    fcd_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctx      (ctx),
        .mode     (mode),
        .req      (req),
        .op_kind  (kind),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .op_addr2 (op_addr2),
        .op_data2 (op_data2)
    );

    fcd_stat_cap #(.SW(SW)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .rd_act   (rd_act),
        .stat_in  (stat_in),
        .stat_out (stat_out)
    );

    assign rd_sel     = (ctx == CX_BUSY) ? RM_STATUS : mode;
    assign op_kind    = kind;
    assign op_start   = req.start;
    assign susp_req   = req.susp;
    assign resume_req = req.resume;
    assign clr_req    = req.clr;
    assign seq_err    = req.err;
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
    parameter int AW = 21,
    parameter int SW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_stb,
    input logic          busy,
    input logic          ers_susp,
    input logic          prg_susp,
    input logic          rd_act,
    input logic [SW-1:0] stat_out,
    input logic          op_start,
    input logic [2:0]    op_kind,
    input logic [AW-1:0] op_addr,
    input logic [AW-1:0] op_addr2,
    input logic          susp_req,
    input logic          resume_req,
    input logic          clr_req,
    input logic          seq_err
);
    AST_REQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_start || susp_req || resume_req || clr_req || seq_err) |-> $past(wr_stb)); // R4
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        op_start |-> !$past(busy)); // R8
    AST_SUSP_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        susp_req |-> $past(busy)); // R8
    AST_RESUME_ONLY_SUSP: assert property (@(posedge clk) disable iff (rst)
        resume_req |-> ($past(ers_susp || prg_susp) && !$past(busy))); // R9
    AST_NO_START_PSUSP: assert property (@(posedge clk) disable iff (rst)
        op_start |-> !($past(prg_susp) && !$past(ers_susp))); // R9
    AST_DW_PAIR: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_kind == 3'd2) |-> (op_addr[AW-1:1] == op_addr2[AW-1:1])); // R5
    AST_STAT_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_act && $past(rd_act) && $past(rd_act, 2)) |-> $stable(stat_out)); // R11
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({op_start, susp_req, resume_req, clr_req, seq_err})); // R7
endmodule

bind flash_cmd_decoder fcd_chk #(.AW(AW), .SW(SW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .busy       (busy),
    .ers_susp   (ers_susp),
    .prg_susp   (prg_susp),
    .rd_act     (rd_act),
    .stat_out   (stat_out),
    .op_start   (op_start),
    .op_kind    (op_kind),
    .op_addr    (op_addr),
    .op_addr2   (op_addr2),
    .susp_req   (susp_req),
    .resume_req (resume_req),
    .clr_req    (clr_req),
    .seq_err    (seq_err)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
    localparam int AW = 21;
    localparam int DW = 16;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic busy = 1'b0, ers_susp = 1'b0, prg_susp = 1'b0, rd_act = 1'b0;
    logic [SW-1:0] stat_in = '0;
    logic [1:0] rd_sel;
    logic [SW-1:0] stat_out;
    logic op_start, susp_req, resume_req, clr_req, seq_err;
    logic [2:0] op_kind;
    logic [AW-1:0] op_addr, op_addr2;
    logic [DW-1:0] op_data, op_data2;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder #(.AW(AW), .DW(DW), .SW(SW)) i_flash_cmd_decoder (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .ers_susp(ers_susp), .prg_susp(prg_susp), .rd_act(rd_act),
        .stat_in(stat_in), .rd_sel(rd_sel), .stat_out(stat_out), .op_start(op_start),
        .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data), .op_addr2(op_addr2),
        .op_data2(op_data2), .susp_req(susp_req), .resume_req(resume_req),
        .clr_req(clr_req), .seq_err(seq_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] c);
        wr('0, {8'h00, c});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic bit is_setup(input logic [7:0] c);
        return c == 8'h20 || c == 8'h40 || c == 8'h10 || c == 8'h30 || c == 8'h60 || c == 8'hC0;
    endfunction

    function automatic logic [1:0] exp_mode(input logic [7:0] c);
        case (c)
            8'h70:   return 2'd1;
            8'h90:   return 2'd2;
            8'h98:   return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [4:0] reqs();
        return {op_start, susp_req, resume_req, clr_req, seq_err};
    endfunction

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] pool [10];
        pool = '{8'hFF, 8'h70, 8'h90, 8'h98, 8'h50, 8'hB0, 8'hD0, 8'h00, 8'h77, 8'hE5};
        void'($urandom(32'd1234));
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 rd_sel", rd_sel, 0);
        chk("R1 requests", reqs(), 0);

        // R2
        cmd(8'h70); chk("R2 status", rd_sel, 1);
        cmd(8'h90); chk("R2 signature", rd_sel, 2);
        cmd(8'h98); chk("R2 query", rd_sel, 3);
        cmd(8'hFF); chk("R2 array", rd_sel, 0);

        // R3
        cmd(8'h70);
        cmd(8'h50);
        chk("R3 clr pulse", clr_req, 1);
        chk("R3 array", rd_sel, 0);
        @(negedge clk); chk("R3 pulse width", clr_req, 0);

        // R4
        cmd(8'h20); wr(21'h01234, 16'h00D0);
        chk("R4 erase start", op_start, 1);
        chk("R4 erase kind", op_kind, 0);
        chk("R4 erase addr", op_addr, 21'h01234);
        chk("R4 status mode", rd_sel, 1);
        cmd(8'h40); wr(21'h1ABCD, 16'hBEEF);
        chk("R4 prog kind", {op_start, op_kind}, {1'b1, 3'd1});
        chk("R4 prog addr/data", {op_addr, op_data}, {21'h1ABCD, 16'hBEEF});
        cmd(8'h10); wr(21'h00042, 16'h1357);
        chk("R4 alt prog", {op_start, op_kind, op_data}, {1'b1, 3'd1, 16'h1357});

        // R5
        cmd(8'h30); wr(21'h00100, 16'hAAAA); wr(21'h00101, 16'h5555);
        chk("R5 dw start", {op_start, op_kind}, {1'b1, 3'd2});
        chk("R5 dw first", {op_addr, op_data}, {21'h00100, 16'hAAAA});
        chk("R5 dw second", {op_addr2, op_data2}, {21'h00101, 16'h5555});
        cmd(8'h30); wr(21'h00100, 16'h1111); wr(21'h00102, 16'h2222);
        chk("R5 dw mismatch", reqs(), 5'b00001);

        // R6
        cmd(8'h60); wr(21'h08000, 16'h0001);
        chk("R6 protect", {op_start, op_kind, op_addr}, {1'b1, 3'd3, 21'h08000});
        cmd(8'h60); wr(21'h10000, 16'h00D0);
        chk("R6 unprotect", {op_start, op_kind}, {1'b1, 3'd4});
        cmd(8'h60); wr(21'h18000, 16'h002F);
        chk("R6 lock", {op_start, op_kind}, {1'b1, 3'd5});
        cmd(8'hC0); wr(21'h00085, 16'hC0DE);
        chk("R6 preg", {op_start, op_kind, op_addr, op_data}, {1'b1, 3'd6, 21'h00085, 16'hC0DE});

        // R7
        cmd(8'h20); cmd(8'hFF);
        chk("R7 erase bad confirm", reqs(), 5'b00001);
        cmd(8'h60); cmd(8'h77);
        chk("R7 protect bad confirm", reqs(), 5'b00001);
        cmd(8'h40); chk("R7 back to idle", op_start, 0);
        wr(21'h3, 16'h0001); chk("R7 idle accepts new seq", op_start, 1);

        // R8
        cmd(8'h90);
        @(negedge clk); busy = 1'b1;
        @(negedge clk); chk("R8 busy reads status", rd_sel, 1);
        cmd(8'hFF); chk("R8 FF ignored", reqs(), 0);
        cmd(8'h40); chk("R8 40 ignored", reqs(), 0);
        cmd(8'hB0); chk("R8 suspend", susp_req, 1);
        chk("R8 still status", rd_sel, 1);
        busy = 1'b0;
        @(negedge clk); chk("R8 mode kept", rd_sel, 2);
        cmd(8'hFF); chk("R8 no pending setup", {op_start, rd_sel}, {1'b0, 2'd0});

        // R9 erase suspended
        ers_susp = 1'b1;
        cmd(8'h40); wr(21'h00777, 16'h4242);
        chk("R9 esusp program", {op_start, op_kind, op_data}, {1'b1, 3'd1, 16'h4242});
        cmd(8'h90); cmd(8'h20);
        chk("R9 esusp erase illegal", {reqs(), rd_sel}, {5'b0, 2'd0});
        cmd(8'hD0);
        chk("R9 esusp resume", {reqs(), rd_sel}, {5'b00100, 2'd1});
        cmd(8'h60); wr(21'h20000, 16'h0001);
        chk("R9 esusp protect", {op_start, op_kind}, {1'b1, 3'd3});
        ers_susp = 1'b0;
        // R9 program suspended
        prg_susp = 1'b1;
        cmd(8'h98); cmd(8'h40);
        chk("R9 psusp program illegal", {reqs(), rd_sel}, {5'b0, 2'd0});
        wr(21'h5, 16'h0070);
        chk("R9 psusp no setup", {op_start, rd_sel}, {1'b0, 2'd1});
        cmd(8'h60);
        chk("R9 psusp protect illegal", {reqs(), rd_sel}, {5'b0, 2'd0});
        cmd(8'hD0);
        chk("R9 psusp resume", {resume_req, rd_sel}, {1'b1, 2'd1});
        prg_susp = 1'b0;

        // R10
        cmd(8'h90); cmd(8'h33);
        chk("R10 invalid", {reqs(), rd_sel}, {5'b0, 2'd0});
        cmd(8'h70); cmd(8'hB0);
        chk("R10 suspend idle", {reqs(), rd_sel}, {5'b0, 2'd0});
        cmd(8'h98); cmd(8'hD0);
        chk("R10 resume idle", {reqs(), rd_sel}, {5'b0, 2'd0});

        // R11
        stat_in = 8'h80;
        @(negedge clk); rd_act = 1'b1;
        @(negedge clk); stat_in = 8'h00;
        idle(3);
        chk("R11 held", stat_out, 8'h80);
        rd_act = 1'b0;
        idle(2);
        chk("R11 held after end", stat_out, 8'h80);
        stat_in = 8'h88; rd_act = 1'b1;
        @(negedge clk); stat_in = 8'h01;
        @(negedge clk);
        chk("R11 new access", stat_out, 8'h88);
        rd_act = 1'b0;

        // Random single-cycle commands (R2, R3, R10)
        cmd(8'hFF);
        for (int i = 0; i < 300; i++) begin
            logic [7:0] c;
            if ($urandom_range(0, 2) == 0) begin
                c = 8'($urandom);
                if (is_setup(c)) c = 8'hFF;
            end else begin
                c = pool[$urandom_range(0, 9)];
            end
            cmd(c);
            chk("R2 random mode", rd_sel, exp_mode(c));
            chk("R3 random clr", clr_req, (c == 8'h50));
            chk("R10 random no op", {op_start, susp_req, resume_req, seq_err}, 0);
        end

        // Random busy writes (R8)
        cmd(8'h98);
        busy = 1'b1;
        for (int i = 0; i < 100; i++) begin
            logic [7:0] c;
            c = pool[$urandom_range(0, 9)];
            if (c == 8'h70) c = 8'h90;
            cmd(c);
            chk("R8 random status", rd_sel, 1);
            chk("R8 random susp", {op_start, susp_req, resume_req, clr_req}, {1'b0, c == 8'hB0, 2'b00});
        end
        busy = 1'b0;
        @(negedge clk);
        chk("R8 random mode kept", rd_sel, 3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule